// File: doc/BRIEF.md
# Interlocked Asynchronous Bus Read Link

This block pairs a read requester with a memory responder that talk over one shared word-wide bus and three control lines: a read request, an acknowledge and a data-ready flag. Neither side assumes it shares a clock with the other. Every control input passes through a two-flop synchronizer before either state machine acts on it. Each step waits for the other side's line to change. The same bus first carries the address from requester to responder and then carries the data word back.

The local logic starts a read by pulsing `start` with an address. The requester later returns the fetched word on `rdata` and pulses `done`. The responder keeps a small word array. It is filled through a simple write port and read with a registered read path, so block RAM can be used. The bus and its control lines are also brought out as outputs, so that the protocol can be observed.

Top module: `async_read_link`

## Requirements
- R1: While reset is high and on the cycle after it, `bus_readreq`, `bus_ack`, `bus_datardy`, `bus_req_drv`, `bus_rsp_drv`, `done` and `busy` are all 0.
- R2: A read started with address A ends with `done` high for one cycle and `rdata` equal to the word last written to array entry A through the fill port.
- R3: `done` is a single-cycle pulse. `rdata` keeps the captured word unchanged until the next accepted `start`.
- R4: A `start` that arrives while `busy` is 1 is ignored. The running read returns the word for its own address, and no second `done` follows.
- R5: `bus_readreq` falls only after `bus_ack` was high in the cycle before. The requester drives the bus (`bus_req_drv`) exactly while `bus_readreq` is high.
- R6: `bus_ack` falls only when `bus_readreq` and `bus_datardy` were both low in the cycle before.
- R7: `bus_datardy` is high exactly while the responder drives the bus (`bus_rsp_drv`). It falls only after `bus_ack` was high in the cycle before.
- R8: When `bus_ack` rises while `bus_readreq` is low (the requester's data acknowledge), `bus_datardy` is high.
- R9: `bus_req_drv` and `bus_rsp_drv` are never both 1. When `bus_rsp_drv` rises, `bus_req_drv` was 0 in the cycle before.
- R10: A fill write to an entry that has already been read changes what the next read of that entry returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both controllers |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a read |
| addr | input | AW | Address of the word to read |
| fill_we | input | 1 | Array write enable |
| fill_addr | input | AW | Array write address |
| fill_data | input | DW | Array write data |
| done | output | 1 | One-cycle pulse when a read completes |
| busy | output | 1 | Requester has a read in progress |
| rdata | output | DW | Captured read word |
| bus_readreq | output | 1 | Read request line |
| bus_ack | output | 1 | Acknowledge line (either side) |
| bus_datardy | output | 1 | Data-ready line |
| bus_req_drv | output | 1 | Requester drives the shared bus |
| bus_rsp_drv | output | 1 | Responder drives the shared bus |
| bus_data | output | DW | Resolved shared bus value |

## Verification
The bench targets stale synchronized levels. If a side acted on an acknowledge left over from an earlier step, it would drop its request before the address was latched, or release data before the word was captured. Either way a wrong word would come back. Back-to-back reads and a `start` pulsed during a read check that a read is neither lost nor started twice. Every cycle the bench also watches the bus for a handover with no idle gap, and for a control line that falls before its partner has answered.

// File: rtl/async_read_pkg.sv
package async_read_pkg;
  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_WAITD, RQ_FIN, RQ_CLR
  } rq_state_t;

  typedef enum logic [2:0] {
    RS_IDLE, RS_HOLD, RS_TURN, RS_DRIVE, RS_REL
  } rs_state_t;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/read_requester.sv
module read_requester
  import async_read_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr,
  output logic          done,
  output logic          busy,
  output logic [DW-1:0] rdata,
  input  logic          ack_in,
  input  logic          drdy_in,
  input  logic [DW-1:0] bus_in,
  output logic          readreq,
  output logic          ack_out,
  output logic          oe,
  output logic [DW-1:0] dout
);
  logic [1:0] s_q;
  logic       ack_s, drdy_s;
  rq_state_t  st;

  sync_2ff #(.W(2)) u_sync (.clk(clk), .rst(rst), .d({ack_in, drdy_in}), .q(s_q));
  assign ack_s  = s_q[1];
  assign drdy_s = s_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RQ_IDLE;
      done    <= 1'b0;
      busy    <= 1'b0;
      rdata   <= '0;
      readreq <= 1'b0;
      ack_out <= 1'b0;
      oe      <= 1'b0;
      dout    <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        RQ_IDLE: if (start) begin
          dout    <= DW'(addr);
          oe      <= 1'b1;
          readreq <= 1'b1;
          busy    <= 1'b1;
          st      <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) begin
          readreq <= 1'b0;
          oe      <= 1'b0;
          st      <= RQ_WAITD;
        end
        RQ_WAITD: if (drdy_s) begin
          rdata   <= bus_in;
          ack_out <= 1'b1;
          st      <= RQ_FIN;
        end
        RQ_FIN: if (!drdy_s) begin
          ack_out <= 1'b0;
          st      <= RQ_CLR;
        end
        RQ_CLR: if (!ack_s) begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= RQ_IDLE;
        end
        default: st <= RQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/read_responder.sv
module read_responder
  import async_read_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic          readreq_in,
  input  logic          ack_in,
  input  logic [DW-1:0] bus_in,
  output logic          ack_out,
  output logic          drdy,
  output logic          oe,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [AW-1:0] lat_addr;
  logic [1:0]    s_q;
  logic          rreq_s, ack_s;
  rs_state_t     st;

  sync_2ff #(.W(2)) u_sync (.clk(clk), .rst(rst), .d({readreq_in, ack_in}), .q(s_q));
  assign rreq_s = s_q[1];
  assign ack_s  = s_q[0];

  always_ff @(posedge clk) begin
    if (fill_we) mem[fill_addr] <= fill_data;
    rd_q <= mem[lat_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RS_IDLE;
      lat_addr <= '0;
      ack_out  <= 1'b0;
      drdy     <= 1'b0;
      oe       <= 1'b0;
      dout     <= '0;
    end else begin
      unique case (st)
        RS_IDLE: if (rreq_s) begin
          lat_addr <= bus_in[AW-1:0];
          ack_out  <= 1'b1;
          st       <= RS_HOLD;
        end
        RS_HOLD: if (!rreq_s) begin
          ack_out <= 1'b0;
          st      <= RS_TURN;
        end
        RS_TURN: if (!ack_s) begin
          dout <= rd_q;
          oe   <= 1'b1;
          drdy <= 1'b1;
          st   <= RS_DRIVE;
        end
        RS_DRIVE: if (ack_s) begin
          oe   <= 1'b0;
          drdy <= 1'b0;
          st   <= RS_REL;
        end
        RS_REL: if (!ack_s) st <= RS_IDLE;
        default: st <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_read_link.sv
module async_read_link #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  output logic          done,
  output logic          busy,
  output logic [DW-1:0] rdata,
  output logic          bus_readreq,
  output logic          bus_ack,
  output logic          bus_datardy,
  output logic          bus_req_drv,
  output logic          bus_rsp_drv,
  output logic [DW-1:0] bus_data
);
  logic          rq_ack, rs_ack;
  logic [DW-1:0] rq_dout, rs_dout;

  assign bus_ack  = rq_ack | rs_ack;
  assign bus_data = bus_req_drv ? rq_dout : (bus_rsp_drv ? rs_dout : '0);

  read_requester #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst(rst), .start(start), .addr(addr),
    .done(done), .busy(busy), .rdata(rdata),
    .ack_in(bus_ack), .drdy_in(bus_datardy), .bus_in(bus_data),
    .readreq(bus_readreq), .ack_out(rq_ack), .oe(bus_req_drv), .dout(rq_dout)
  );

  read_responder #(.AW(AW), .DW(DW)) u_rsp (
    .clk(clk), .rst(rst), .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .readreq_in(bus_readreq), .ack_in(bus_ack), .bus_in(bus_data),
    .ack_out(rs_ack), .drdy(bus_datardy), .oe(bus_rsp_drv), .dout(rs_dout)
  );
endmodule

// File: rtl/async_read_link_chk.sv
module async_read_link_chk (
  input logic clk,
  input logic rst,
  input logic done,
  input logic busy,
  input logic bus_readreq,
  input logic bus_ack,
  input logic bus_datardy,
  input logic bus_req_drv,
  input logic bus_rsp_drv
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !(bus_readreq || bus_ack || bus_datardy || bus_req_drv || bus_rsp_drv || done || busy));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_req_falls_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_readreq) |-> $past(bus_ack));

  assert_req_drive_window_R5: assert property (@(posedge clk) disable iff (rst)
    bus_req_drv == bus_readreq);

  assert_ack_falls_late_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack) |-> (!$past(bus_readreq) && !$past(bus_datardy)));

  assert_drdy_with_drive_R7: assert property (@(posedge clk) disable iff (rst)
    bus_datardy == bus_rsp_drv);

  assert_drdy_falls_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_datardy) |-> $past(bus_ack));

  assert_data_ack_needs_drdy_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_ack) && !bus_readreq) |-> bus_datardy);

  assert_single_driver_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_req_drv && bus_rsp_drv));

  assert_turnaround_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rsp_drv) |-> !$past(bus_req_drv));
endmodule

bind async_read_link async_read_link_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .busy(busy),
  .bus_readreq(bus_readreq), .bus_ack(bus_ack), .bus_datardy(bus_datardy),
  .bus_req_drv(bus_req_drv), .bus_rsp_drv(bus_rsp_drv)
);

// File: tb/test_async_read_link.sv
module test_async_read_link;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NV = 8;
  localparam int TMO = 60;

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] w; } vec_t;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 16'h1234}, '{4'hF, 16'hFFFF}, '{4'h5, 16'h0000}, '{4'hA, 16'hA5C3},
    '{4'h3, 16'h8001}, '{4'hC, 16'h7FFE}, '{4'h9, 16'h0F0F}, '{4'h6, 16'hBEEF}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, fill_we = 1'b0;
  logic [AW-1:0] addr = '0, fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic done, busy, bus_readreq, bus_ack, bus_datardy, bus_req_drv, bus_rsp_drv;
  logic [DW-1:0] rdata, bus_data;

  int n_checks = 0, n_fail = 0;
  int v5 = 0, v6 = 0, v7 = 0, v8 = 0, v9 = 0, n_done = 0;
  logic p_rr = 0, p_ack = 0, p_dr = 0, p_qd = 0, p_sd = 0;

  always #2 clk = ~clk;

  async_read_link #(.AW(AW), .DW(DW)) i_async_read_link (
    .clk(clk), .rst(rst), .start(start), .addr(addr),
    .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .done(done), .busy(busy), .rdata(rdata),
    .bus_readreq(bus_readreq), .bus_ack(bus_ack), .bus_datardy(bus_datardy),
    .bus_req_drv(bus_req_drv), .bus_rsp_drv(bus_rsp_drv), .bus_data(bus_data)
  );

  // Protocol monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (done) n_done++;
      if ((p_rr && !bus_readreq && !p_ack) || (bus_req_drv != bus_readreq)) v5++;
      if (p_ack && !bus_ack && (p_rr || p_dr)) v6++;
      if ((bus_datardy != bus_rsp_drv) || (p_dr && !bus_datardy && !p_ack)) v7++;
      if (!p_ack && bus_ack && !bus_readreq && !bus_datardy) v8++;
      if ((bus_req_drv && bus_rsp_drv) || (!p_sd && bus_rsp_drv && p_qd)) v9++;
    end
    p_rr = bus_readreq; p_ack = bus_ack; p_dr = bus_datardy;
    p_qd = bus_req_drv; p_sd = bus_rsp_drv;
  end

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic [DW-1:0] w);
    @(negedge clk); fill_we = 1'b1; fill_addr = a; fill_data = w;
    @(negedge clk); fill_we = 1'b0;
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] got, output logic ok);
    ok = 1'b0;
    @(negedge clk); start = 1'b1; addr = a;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < TMO; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; got = rdata; break; end
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] got, held;
    logic ok;
    int d0;
    repeat (4) @(negedge clk);
    // R1: quiet while in reset
    check(!(bus_readreq || bus_ack || bus_datardy || bus_req_drv || bus_rsp_drv || done || busy),
          "R1 reset state", {bus_readreq, bus_ack, bus_datardy, bus_req_drv, bus_rsp_drv, done, busy}, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!(bus_readreq || bus_req_drv || bus_rsp_drv || busy), "R1 after reset",
          {bus_readreq, bus_req_drv, bus_rsp_drv, busy}, '0);

    for (int k = 0; k < NV; k++) fill(VECS[k].a, VECS[k].w);

    // R2: table walk
    for (int k = 0; k < NV; k++) begin
      read_word(VECS[k].a, got, ok);
      check(ok, "R2 done seen", DW'(ok), 1);
      check(got == VECS[k].w, "R2 read word", got, VECS[k].w);
      @(negedge clk);
      check(!done, "R3 done one cycle", DW'(done), 0);
    end

    // R3: word held until the next start
    held = rdata;
    repeat (20) @(negedge clk);
    check(rdata == held, "R3 rdata held", rdata, held);

    // R4: start during a read is ignored
    d0 = n_done;
    @(negedge clk); start = 1'b1; addr = VECS[3].a;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy, "R4 busy during read", DW'(busy), 1);
    start = 1'b1; addr = VECS[4].a;
    @(negedge clk); start = 1'b0;
    repeat (TMO) @(negedge clk);
    check(rdata == VECS[3].w, "R4 original address served", rdata, VECS[3].w);
    check(n_done - d0 == 1, "R4 single done", DW'(n_done - d0), 1);

    // R10: overwrite then re-read
    fill(VECS[0].a, 16'h5A5A);
    read_word(VECS[0].a, got, ok);
    check(ok && got == 16'h5A5A, "R10 new word after fill", got, 16'h5A5A);

    // Back-to-back reads with no idle gap after done (R2)
    read_word(VECS[1].a, got, ok);
    read_word(VECS[2].a, got, ok);
    check(ok && got == VECS[2].w, "R2 back-to-back read", got, VECS[2].w);

    check(v5 == 0, "R5 request/ack order", DW'(v5), 0);
    check(v6 == 0, "R6 ack release order", DW'(v6), 0);
    check(v7 == 0, "R7 data-ready order", DW'(v7), 0);
    check(v8 == 0, "R8 data ack with data-ready", DW'(v8), 0);
    check(v9 == 0, "R9 bus turnaround", DW'(v9), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule